// File: doc/BRIEF.md
# Storage-controller function configuration header

This block holds the 256-byte configuration space of one storage-controller function. The bus interface logic presents one configuration cycle at a time. It supplies a dword index, four byte enables and a 32-bit data word, and it raises a write strobe for one clock on a write. The block keeps every byte of the space in its own register. It fills each byte with its reset value, and it applies a fixed policy to each byte address.

Several bytes have fixed values: the identification bytes, the class-code bytes and the header-type byte. The command byte keeps only its two implemented bits. Two bytes of the command/status word ignore writes. Two address regions drop whole write cycles. The I/O base register for the 16-byte bus-master window is always marked as an I/O-space base. The block presents the window base as a decoded address. It also gives a one-cycle pulse whenever a write alters any byte of that register, so the downstream address decoder can move the window. A decoded base of zero means the window is absent. One channel-timing byte per channel resets to an enabled value, and only for the channels the build enables.

Top module: `pci_cfg_hdr`

## Requirements
- R1: Byte addresses 0x00 to 0x03 always read 0x86, 0x80, 0x10 and 0x70. Bytes 0x09, 0x0A and 0x0B always read 0x80, 0x01 and 0x01, and byte 0x0E always reads 0x00. Writes leave all of these unchanged.
- R2: After reset, byte 0x04 reads 0x01, byte 0x06 reads 0x80, byte 0x07 reads 0x02 and the dword at 0x20 reads 0x00000001. Every byte that no other requirement names reads 0x00.
- R3: A write to byte 0x04 stores the written value AND 0x05. Writes to bytes 0x05 and 0x06 have no effect.
- R4: A write cycle whose dword address lies in 0x10 to 0x1F, or in 0x24 to 0x3F, changes no byte.
- R5: A write to byte 0x20 stores bits 7:2 as written, with bit 1 cleared and bit 0 set.
- R6: `base_chg_o` is high for exactly the one cycle after a write edge that changed the stored value of any byte from 0x20 to 0x23. A write that leaves those bytes unchanged produces no pulse.
- R7: `io_base_o` equals the dword at 0x20 with bits 3:0 cleared. It takes its new value on the same edge on which the pulse of R6 rises, and it never changes without that pulse.
- R8: For channel c, byte 0x40+2c resets to 0x00. Byte 0x41+2c resets to 0x80 if bit c of CHAN_EN is set, and to 0x00 otherwise. Byte 0x44 resets to 0x00.
- R9: Any other byte, outside the regions of R4, stores the written byte on a write whose byte enable for that lane is 1. A lane whose byte enable is 0 keeps its old value.
- R10: `rdata_o` returns the four bytes of the addressed dword: the lowest address in bits 7:0 and the highest in bits 31:24. The byte enables do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| dw_addr_i | input | 6 | Dword index of the access (byte address bits 7:2) |
| be_i | input | 4 | Byte enables, bit n selects byte lane n |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rdata_o | output | 32 | Contents of the addressed dword |
| io_base_o | output | 32 | Decoded bus-master window base |
| base_chg_o | output | 1 | One-cycle pulse when the base register changed |

## Verification
The bench builds the block with two channels and CHAN_EN set to 2'b01. Both the enabled and the disabled reset value of the channel-timing bytes are therefore observed in one run. The bench reads all 64 dwords after reset. It then writes every dword with all-ones, all-zeros and two alternating patterns, and it compares the whole space after each pass. A sweep of all 16 byte-enable values on the command dword, the base dword and a plain timing dword covers lane masking, the forced base bits and the cases with and without a change pulse.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  typedef enum logic [2:0] {
    BK_RW,
    BK_RO,
    BK_IGN,
    BK_CMD,
    BK_BAR_LO,
    BK_BAR_HI
  } bkind_e;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DW_W      = ADDR_W - 2;
  localparam int unsigned NBYTES    = 1 << ADDR_W;
  localparam logic [7:0]  CMD_WMASK = 8'h05;
  localparam logic [7:0]  BAR_ADDR  = 8'h20;
  localparam logic [7:0]  TIM_BASE  = 8'h40;
  localparam logic [7:0]  TIM_EN    = 8'h80;

  function automatic bkind_e kind_of(input logic [7:0] a);
    bkind_e k;
    if (a inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h09, 8'h0A, 8'h0B, 8'h0E})
      k = BK_RO;
    else if (a inside {8'h05, 8'h06}) k = BK_IGN;
    else if (a == 8'h04)              k = BK_CMD;
    else if (a == BAR_ADDR)           k = BK_BAR_LO;
    else if (a inside {[8'h21:8'h23]}) k = BK_BAR_HI;
    else                              k = BK_RW;
    return k;
  endfunction

  // whole write cycle dropped by its starting dword
  function automatic logic drop_dw(input logic [DW_W-1:0] dw);
    return (dw inside {[6'h04:6'h07]}) || (dw inside {[6'h09:6'h0F]});
  endfunction

  function automatic logic [7:0] reset_byte(input int unsigned a,
                                            input logic [31:0] id_word,
                                            input logic [23:0] class_code,
                                            input int unsigned n_chan,
                                            input logic [7:0]  chan_en);
    logic [7:0] v;
    int unsigned off;
    v = 8'h00;
    if (a < 4)                       v = id_word[8*a +: 8];
    else if (a >= 9 && a <= 11)      v = class_code[8*(a-9) +: 8];
    else if (a == 4)                 v = 8'h01;
    else if (a == 6)                 v = 8'h80;
    else if (a == 7)                 v = 8'h02;
    else if (a == 32'(BAR_ADDR))     v = 8'h01;
    else if (a >= 32'(TIM_BASE) && a < 32'(TIM_BASE) + 2*n_chan) begin
      off = a - 32'(TIM_BASE);
      if (off[0] && chan_en[off >> 1]) v = TIM_EN;
    end
    return v;
  endfunction

endpackage

// File: rtl/cfg_lane_wr.sv
module cfg_lane_wr
  import pci_cfg_pkg::*;
#(
  parameter int unsigned LANE = 0
) (
  input  logic            wr_en_i,
  input  logic [DW_W-1:0] dw_addr_i,
  input  logic            be_i,
  input  logic [7:0]      wbyte_i,
  input  logic [7:0]      old_i,
  output logic            we_o,
  output logic [7:0]      nbyte_o,
  output logic            bar_chg_o
);
  localparam logic [1:0] LANE_SEL = 2'(LANE);

  logic [7:0] byte_addr;
  bkind_e     kind;

  assign byte_addr = {dw_addr_i, LANE_SEL};
  assign kind      = kind_of(byte_addr);

  always_comb begin
    nbyte_o = wbyte_i;
    we_o    = wr_en_i && be_i && !drop_dw(dw_addr_i);
    unique case (kind)
      BK_RO, BK_IGN: we_o = 1'b0;
      BK_CMD:        nbyte_o = wbyte_i & CMD_WMASK;
      BK_BAR_LO:     nbyte_o = {wbyte_i[7:2], 2'b01};
      default:       ;
    endcase
  end

  assign bar_chg_o = we_o && (kind inside {BK_BAR_LO, BK_BAR_HI}) && (nbyte_o != old_i);

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import pci_cfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h7010_8086,
  parameter logic [23:0] CLASS_CODE = 24'h01_01_80,
  parameter int unsigned NUM_CHAN   = 2,
  parameter logic [7:0]  CHAN_MASK  = 8'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW_W-1:0]     dw_addr_i,
  input  logic [3:0]          we_i,
  input  logic [3:0][7:0]     wbytes_i,
  output logic [3:0][7:0]     rbytes_o,
  output logic [31:0]         bar_o
);
  localparam int unsigned NDW     = NBYTES / 4;
  localparam int unsigned BAR_DW  = 32'(BAR_ADDR) / 4;

  logic [7:0] mem [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [7:0]      RST = reset_byte(i, ID_WORD, CLASS_CODE, NUM_CHAN, CHAN_MASK);
    localparam logic [DW_W-1:0] DW  = DW_W'(i / 4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem[i] <= RST;
      else if (we_i[i % 4] && dw_addr_i == DW) mem[i] <= wbytes_i[i % 4];
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_rd
    assign rbytes_o[l] = mem[{dw_addr_i, 2'(l)}];
    assign bar_o[8*l +: 8] = mem[BAR_DW*4 + l];
  end

  if (NDW != (1 << DW_W)) begin : g_bad_geom
    initial $error("cfg_byte_store: geometry mismatch");
  end

endmodule

// File: rtl/cfg_base_track.sv
module cfg_base_track #(
  parameter int unsigned WIN_BITS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        chg_i,
  input  logic [31:0] bar_i,
  output logic [31:0] io_base_o,
  output logic        chg_o
);
  assign io_base_o = {bar_i[31:WIN_BITS], {WIN_BITS{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_o <= 1'b0;
    else         chg_o <= chg_i;
  end

endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h7010_8086,
  parameter logic [23:0] CLASS_CODE = 24'h01_01_80,
  parameter int unsigned NUM_CHAN   = 2,
  parameter logic [1:0]  CHAN_EN    = 2'b11,
  parameter int unsigned WIN_BITS   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [5:0]  dw_addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [31:0] io_base_o,
  output logic        base_chg_o
);
  localparam logic [7:0] CHAN_MASK = 8'(CHAN_EN);

  logic [3:0]      lane_we;
  logic [3:0]      lane_chg;
  logic [3:0][7:0] lane_new;
  logic [3:0][7:0] cur_bytes;
  logic [31:0]     bar_word;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    cfg_lane_wr #(.LANE(l)) u_lane (
      .wr_en_i   (wr_en_i),
      .dw_addr_i (dw_addr_i),
      .be_i      (be_i[l]),
      .wbyte_i   (wdata_i[8*l +: 8]),
      .old_i     (cur_bytes[l]),
      .we_o      (lane_we[l]),
      .nbyte_o   (lane_new[l]),
      .bar_chg_o (lane_chg[l])
    );
  end

  cfg_byte_store #(
    .ID_WORD    (ID_WORD),
    .CLASS_CODE (CLASS_CODE),
    .NUM_CHAN   (NUM_CHAN),
    .CHAN_MASK  (CHAN_MASK)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dw_addr_i (dw_addr_i),
    .we_i      (lane_we),
    .wbytes_i  (lane_new),
    .rbytes_o  (cur_bytes),
    .bar_o     (bar_word)
  );

  cfg_base_track #(.WIN_BITS(WIN_BITS)) u_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_i     (|lane_chg),
    .bar_i     (bar_word),
    .io_base_o (io_base_o),
    .chg_o     (base_chg_o)
  );

  assign rdata_o = cur_bytes;

endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [5:0]  dw_addr_i,
  input logic [31:0] rdata_o,
  input logic [31:0] io_base_o,
  input logic        base_chg_o
);
  assert_id_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_addr_i == 6'h00) |-> (rdata_o == 32'h7010_8086));

  assert_class_bytes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_addr_i == 6'h02) |-> (rdata_o[31:8] == 24'h01_01_80));

  assert_cmd_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_addr_i == 6'h01) |-> ((rdata_o[7:0] & 8'hFA) == 8'h00 && rdata_o[23:8] == 16'h8000));

  assert_bar_io_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_addr_i == 6'h08) |-> (rdata_o[1:0] == 2'b01));

  assert_pulse_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_chg_o |-> $past(wr_en_i));

  assert_base_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_chg_o |-> $stable(io_base_o));

  assert_base_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_base_o[3:0] == 4'h0));

endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .dw_addr_i  (dw_addr_i),
  .rdata_o    (rdata_o),
  .io_base_o  (io_base_o),
  .base_chg_o (base_chg_o)
);

// File: tb/tb_pci_cfg_hdr.sv
module tb_pci_cfg_hdr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  dw_addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, io_base;
  logic        base_chg;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [256];

  always #2.5 clk = ~clk;

  pci_cfg_hdr #(.NUM_CHAN(2), .CHAN_EN(2'b01)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .dw_addr_i(dw_addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .io_base_o(io_base),
    .base_chg_o(base_chg)
  );

  function automatic logic is_fixed(int a);
    return a inside {0, 1, 2, 3, 9, 10, 11, 14};
  endfunction

  function automatic logic dropped(int dw);
    return (dw*4 >= 'h10 && dw*4 <= 'h1F) || (dw*4 >= 'h24 && dw*4 <= 'h3F);
  endfunction

  function automatic string tag_of(int dw);
    if (dw == 0 || dw == 2 || dw == 3) return "R1";
    if (dw == 1)                       return "R3";
    if (dropped(dw))                   return "R4";
    if (dw == 8)                       return "R5";
    if (dw == 16 || dw == 17)          return "R8";
    return "R9/R10";
  endfunction

  function automatic logic [31:0] mword(int dw);
    return {m[dw*4+3], m[dw*4+2], m[dw*4+1], m[dw*4]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic read_chk(int dw, string req);
    @(negedge clk);
    dw_addr = 6'(dw);
    #1;
    check(req, rdata, mword(dw));
  endtask

  task automatic sweep_read(string pre);
    for (int dw = 0; dw < 64; dw++) read_chk(dw, {pre, tag_of(dw)});
  endtask

  task automatic wr(int dw, logic [3:0] b, logic [31:0] d);
    logic [31:0] old_bar;
    logic [31:0] exp_base;
    logic exp_chg;
    old_bar = mword(8);
    for (int l = 0; l < 4; l++) begin
      int a;
      logic [7:0] v;
      a = dw*4 + l;
      v = d[8*l +: 8];
      if (b[l] && !dropped(dw) && !is_fixed(a) && a != 5 && a != 6) begin
        if (a == 4)         m[a] = v & 8'h05;
        else if (a == 'h20) m[a] = {v[7:2], 2'b01};
        else                m[a] = v;
      end
    end
    exp_chg  = (mword(8) != old_bar);
    exp_base = {mword(8)[31:4], 4'h0};
    @(negedge clk);
    dw_addr = 6'(dw); be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 pulse", {31'd0, base_chg}, {31'd0, exp_chg});
    check("R7 base", io_base, exp_base);
    @(negedge clk);
    check("R6 single cycle", {31'd0, base_chg}, 32'd0);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) m[a] = 8'h00;
    {m[3], m[2], m[1], m[0]} = 32'h7010_8086;
    m[9] = 8'h80; m[10] = 8'h01; m[11] = 8'h01;
    m[4] = 8'h01; m[6] = 8'h80; m[7] = 8'h02;
    m['h20] = 8'h01;
    m['h41] = 8'h80;            // channel 0 enabled, channel 1 not (R8)
    repeat (3) @(negedge clk);
    check("R2 pulse idle", {31'd0, base_chg}, 32'd0);
    rst_n = 1'b1;
    check("R2/R7 base after reset", io_base, 32'h0);
    sweep_read("R2 reset ");

    // full-dword pattern passes over the whole space
    for (int dw = 0; dw < 64; dw++) wr(dw, 4'hF, 32'hFFFF_FFFF);
    sweep_read("ones ");
    for (int dw = 0; dw < 64; dw++) wr(dw, 4'hF, 32'h0000_0000);
    sweep_read("zeros ");
    for (int dw = 0; dw < 64; dw++) wr(dw, 4'hF, 32'hA5C3_5A3C ^ (dw * 32'h0101_0101));
    sweep_read("pat ");
    for (int dw = 63; dw >= 0; dw--) wr(dw, 4'hF, 32'h5A3C_A5C3 + dw);
    sweep_read("pat2 ");

    // byte-enable sweeps: R9 and R10 lane masking
    for (int b = 0; b < 16; b++) begin
      wr(1, 4'(b), {4'(b), 4'hF, 4'(b), 4'hE, 4'(b), 4'hD, 4'(b), 4'h7});
      read_chk(1, "R3 be sweep");
      wr(8, 4'(b), {4'(b), 4'h3, 4'(b), 4'h2, 4'(b), 4'h1, 4'(b), 4'hE});
      read_chk(8, "R5/R6 be sweep");
      wr(17, 4'(b), {4'(b), 4'h9, 4'(b), 4'h6, 4'(b), 4'h3, 4'(b), 4'h0});
      read_chk(17, "R9/R10 be sweep");
    end

    // same-value base write: no pulse (R6)
    wr(8, 4'hF, mword(8));
    wr(8, 4'h1, 32'h0000_00F2);
    wr(8, 4'h1, 32'h0000_00F0);   // stores F1 again, no pulse
    read_chk(8, "R5 forced bits");
    wr(8, 4'hF, 32'h0000_0000);   // base absent
    check("R7 absent window", io_base, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule